// File: doc/BRIEF.md
# Lookahead Dual-Rail Pipeline Controller

This block is a clocked, cycle-level model of a dual-rail dynamic-logic pipeline in which each stage is steered by the two stages after it. Words travel as dual-rail tokens. Each bit is a rail pair: `00` is the spacer, `01` is logic 0 and `10` is logic 1. Each stage alternates between evaluate, where it captures a token from its predecessor, and precharge, where it resets to the spacer. Every protocol event takes one clock step.

A stage drops into precharge once its successor has completed on the token it handed over. It leaves precharge as soon as the stage two places ahead reports completion, so it does not wait for its successor to reset. This lets a stage start its next cycle early. Because neighbouring tokens must stay apart by a spacer, a stalled pipeline fills only half of its stages.

A producer offers a dual-rail word with a valid flag and sees an accept strobe. It must return to the spacer (valid low) before it offers the next word. A sink sees the last stage's completion as output valid and answers with a four-phase acknowledge. The per-stage precharge state and completion flags are brought out so that the lookahead behaviour can be observed.

Top module: `lp_pipe`

## Requirements
- R1: While reset is asserted, every stage is in precharge and every stage completion is low. The output rails are all `00`, and `out_valid`, `in_accept` and `code_err` are low. With no input offered, every stage is back in evaluate one clock after the internal reset releases.
- R2: Pair `[2b+1:2b]` carries bit b: `01` is 0, `10` is 1 and `00` is the spacer. `out_rails` never contains the pair `11`. `out_valid` is the last stage's completion: it is high when all pairs are valid, low when all are spacers, and otherwise holds its value.
- R3: `in_accept` is high only while `in_valid` is high, every input pair is `01` or `10`, and stage 0 is empty and in evaluate. A word held on the input after acceptance is not taken again until `in_valid` has been low for at least one clock.
- R4: A word with any `11` pair while `in_valid` is high is never accepted. It sets `code_err` at the next clock, and `code_err` stays high until reset. Later legal words still flow.
- R5: A stage holding a token enters precharge at the clock after its successor's completion has risen on that token. For the last stage, the successor signal is `out_ack`.
- R6: A stage in precharge returns to evaluate at the next clock when the completion two stages ahead is high, even if its successor still holds its completion. It also returns when its successor's completion is low. Two ahead of the second-to-last stage is `out_ack`; two ahead of the last stage is a constant high.
- R7: A stage in precharge outputs only spacers. While a stage's completion stays high, its rails do not change, so one token is never replaced by another without a spacer between them.
- R8: With the sink never acknowledging, an empty pipeline accepts exactly STAGES/2 words. It then settles with completions high in the odd-numbered stages and precharge held in the even-numbered stages.
- R9: Accepted words leave in the order they entered, with no loss and no duplication.
- R10: While `out_valid` is high and `out_ack` is low, `out_valid` stays high and `out_rails` is stable. After `out_ack` is seen high, `out_valid` falls at the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Producer offers a word on `in_rails` |
| in_rails | input | 2*BITS | Dual-rail input word |
| in_accept | output | 1 | Stage 0 captures the offered word at this clock edge |
| out_rails | output | 2*BITS | Dual-rail word held by the last stage |
| out_valid | output | 1 | Completion of the last stage |
| out_ack | input | 1 | Four-phase acknowledge from the sink |
| code_err | output | 1 | Sticky flag for an illegal `11` pair seen on the input |
| stage_pc | output | STAGES | Per-stage precharge state |
| stage_done | output | STAGES | Per-stage completion flags |

## Verification
Timing of each result:
- `in_accept` is combinational and is read one time step after the negative edge at which the word is driven.
- `code_err`, stage phase changes and completion changes each appear one clock after their cause.
- A word first shows on `out_valid` STAGES-1 clocks after the edge at which it was accepted.
- The sink model and the phase monitor run in one negative-edge process. The monitor records the precharge state and the completions one and two stages ahead, and it checks the phase at the next negative edge.
- Direct checks are made at negative edges, counted from the edge that caused the change. For example, `out_valid` is expected low at the second negative edge after the sink is enabled: one edge to raise the acknowledge, and one register stage for the last stage to precharge.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic {
    PH_EVAL      = 1'b0,
    PH_PRECHARGE = 1'b1
  } lp_phase_e;

  localparam logic [1:0] DR_SPACER = 2'b00;
  localparam logic [1:0] DR_ZERO   = 2'b01;
  localparam logic [1:0] DR_ONE    = 2'b10;
  localparam logic [1:0] DR_BAD    = 2'b11;
endpackage

// File: rtl/lp_code_check.sv
module lp_code_check
  import lp_pkg::*;
#(
  parameter int BITS = 4
) (
  input  logic [2*BITS-1:0] rails,
  output logic              all_valid,
  output logic              all_spacer
);
  logic [BITS-1:0] pair_ok;
  logic [BITS-1:0] pair_sp;

  for (genvar g = 0; g < BITS; g++) begin : g_pair
    assign pair_ok[g] = (rails[2*g+1 -: 2] == DR_ZERO) || (rails[2*g+1 -: 2] == DR_ONE);
    assign pair_sp[g] = (rails[2*g+1 -: 2] == DR_SPACER);
  end

  assign all_valid  = &pair_ok;
  assign all_spacer = &pair_sp;
endmodule

// File: rtl/lp_in_guard.sv
module lp_in_guard
  import lp_pkg::*;
#(
  parameter int BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2*BITS-1:0] in_rails,
  output logic              word_ok,
  output logic              word_spacer,
  output logic              err
);
  logic            all_valid;
  logic            all_spacer;
  logic [BITS-1:0] pair_bad;
  logic            err_q;
  logic            err_set;

  lp_code_check #(.BITS(BITS)) u_code (
    .rails      (in_rails),
    .all_valid  (all_valid),
    .all_spacer (all_spacer)
  );

  for (genvar g = 0; g < BITS; g++) begin : g_bad
    assign pair_bad[g] = (in_rails[2*g+1 -: 2] == DR_BAD);
  end

  always_comb begin
    word_ok     = in_valid && all_valid;
    word_spacer = !in_valid || all_spacer;
    err_set     = in_valid && (|pair_bad) && !err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_set) begin
      err_q <= 1'b1;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/lp_stage.sv
module lp_stage
  import lp_pkg::*;
#(
  parameter int BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*BITS-1:0] in_rails,
  input  logic              in_done,
  input  logic              in_spacer,
  input  logic              succ_done,
  input  logic              look_done,
  output logic [2*BITS-1:0] out_rails,
  output logic              out_done,
  output logic              out_pc,
  output logic              take
);
  localparam int RW = 2 * BITS;

  lp_phase_e     phase_q, phase_d;
  logic [RW-1:0] rails_q, rails_d;
  logic          done_q, done_d;
  logic          armed_q, armed_d;
  logic          sent_q, sent_d;
  logic          go_pc, leave_pc;
  logic          nxt_valid, nxt_spacer;

  lp_code_check #(.BITS(BITS)) u_next (
    .rails      (rails_d),
    .all_valid  (nxt_valid),
    .all_spacer (nxt_spacer)
  );

  always_comb begin
    go_pc    = (phase_q == PH_EVAL) && done_q && succ_done && sent_q;
    leave_pc = (phase_q == PH_PRECHARGE) && (look_done || !succ_done);
    take     = (phase_q == PH_EVAL) && !done_q && armed_q && in_done;

    phase_d = phase_q;
    if (go_pc)         phase_d = PH_PRECHARGE;
    else if (leave_pc) phase_d = PH_EVAL;

    rails_d = rails_q;
    if (go_pc)     rails_d = '0;
    else if (take) rails_d = in_rails;

    armed_d = take ? 1'b0 : (armed_q || in_spacer);

    if (take) sent_d = !succ_done;
    else      sent_d = sent_q || ((phase_q == PH_EVAL) && done_q && !succ_done);

    if (nxt_valid)       done_d = 1'b1;
    else if (nxt_spacer) done_d = 1'b0;
    else                 done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PRECHARGE;
      rails_q <= '0;
      done_q  <= 1'b0;
      armed_q <= 1'b0;
      sent_q  <= 1'b0;
    end else begin
      if (go_pc || leave_pc) phase_q <= phase_d;
      if (go_pc || take)     rails_q <= rails_d;
      done_q  <= done_d;
      armed_q <= armed_d;
      sent_q  <= sent_d;
    end
  end

  assign out_rails = rails_q;
  assign out_done  = done_q;
  assign out_pc    = (phase_q == PH_PRECHARGE);
endmodule

// File: rtl/lp_pipe.sv
module lp_pipe #(
  parameter int STAGES = 4,
  parameter int BITS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2*BITS-1:0] in_rails,
  output logic              in_accept,
  output logic [2*BITS-1:0] out_rails,
  output logic              out_valid,
  input  logic              out_ack,
  output logic              code_err,
  output logic [STAGES-1:0] stage_pc,
  output logic [STAGES-1:0] stage_done
);
  localparam int RW = 2 * BITS;

  logic [1:0]        rst_pipe;
  logic              rst_ns;
  logic [RW-1:0]     stage_rails [STAGES];
  logic [STAGES+1:0] done_ext;
  logic [STAGES-1:0] take_v;
  logic              word_ok;
  logic              word_spacer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  assign done_ext = {1'b1, out_ack, stage_done};

  lp_in_guard #(.BITS(BITS)) u_guard (
    .clk         (clk),
    .rst_n       (rst_ns),
    .in_valid    (in_valid),
    .in_rails    (in_rails),
    .word_ok     (word_ok),
    .word_spacer (word_spacer),
    .err         (code_err)
  );

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      lp_stage #(.BITS(BITS)) u_stage (
        .clk       (clk),
        .rst_n     (rst_ns),
        .in_rails  (in_rails),
        .in_done   (word_ok),
        .in_spacer (word_spacer),
        .succ_done (done_ext[i+1]),
        .look_done (done_ext[i+2]),
        .out_rails (stage_rails[i]),
        .out_done  (stage_done[i]),
        .out_pc    (stage_pc[i]),
        .take      (take_v[i])
      );
    end else begin : g_body
      lp_stage #(.BITS(BITS)) u_stage (
        .clk       (clk),
        .rst_n     (rst_ns),
        .in_rails  (stage_rails[i-1]),
        .in_done   (stage_done[i-1]),
        .in_spacer (!stage_done[i-1]),
        .succ_done (done_ext[i+1]),
        .look_done (done_ext[i+2]),
        .out_rails (stage_rails[i]),
        .out_done  (stage_done[i]),
        .out_pc    (stage_pc[i]),
        .take      (take_v[i])
      );
    end
  end

  assign in_accept = take_v[0];
  assign out_rails = stage_rails[STAGES-1];
  assign out_valid = stage_done[STAGES-1];
endmodule

// File: rtl/lp_pipe_chk.sv
module lp_pipe_chk
  import lp_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int BITS   = 4
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              in_valid,
  input logic [2*BITS-1:0] in_rails,
  input logic              in_accept,
  input logic [2*BITS-1:0] out_rails,
  input logic              out_valid,
  input logic              out_ack,
  input logic              code_err,
  input logic [STAGES-1:0] stage_pc,
  input logic [STAGES-1:0] stage_done,
  input logic [2*BITS-1:0] stage_rails [STAGES],
  input logic [STAGES-1:0] take_v
);
  logic [STAGES+1:0] dx;
  logic [BITS-1:0]   in_bad;
  logic [BITS-1:0]   out_bad;

  assign dx = {1'b1, out_ack, stage_done};

  for (genvar g = 0; g < BITS; g++) begin : g_bad
    assign in_bad[g]  = (in_rails[2*g+1 -: 2] == DR_BAD);
    assign out_bad[g] = (out_rails[2*g+1 -: 2] == DR_BAD);
  end

  assert_out_code_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    out_bad == '0);

  assert_accept_legal_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    in_accept |-> (in_valid && in_bad == '0));

  assert_err_set_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_valid && in_bad != '0) |=> code_err);

  assert_err_hold_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    code_err |=> code_err);

  assert_sink_hold_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && !out_ack) |=> (out_valid && $stable(out_rails)));

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    assert_pc_spacer_R7: assert property (@(posedge clk) disable iff (!rst_ns)
      stage_pc[i] |-> (stage_rails[i] == '0));

    assert_token_stable_R7: assert property (@(posedge clk) disable iff (!rst_ns)
      (stage_done[i] && $past(stage_done[i])) |-> $stable(stage_rails[i]));

    assert_lookahead_exit_R6: assert property (@(posedge clk) disable iff (!rst_ns)
      (stage_pc[i] && dx[i+2]) |=> !stage_pc[i]);

    assert_pc_entry_R5: assert property (@(posedge clk) disable iff (!rst_ns)
      $rose(stage_pc[i]) |-> $past(dx[i+1]));

    assert_take_done_R3: assert property (@(posedge clk) disable iff (!rst_ns)
      take_v[i] |=> stage_done[i]);
  end
endmodule

bind lp_pipe lp_pipe_chk #(.STAGES(STAGES), .BITS(BITS)) u_chk (
  .clk         (clk),
  .rst_ns      (rst_ns),
  .in_valid    (in_valid),
  .in_rails    (in_rails),
  .in_accept   (in_accept),
  .out_rails   (out_rails),
  .out_valid   (out_valid),
  .out_ack     (out_ack),
  .code_err    (code_err),
  .stage_pc    (stage_pc),
  .stage_done  (stage_done),
  .stage_rails (stage_rails),
  .take_v      (take_v)
);

// File: tb/lp_pipe_test.sv
module lp_pipe_test;
  localparam int S  = 4;
  localparam int B  = 4;
  localparam int RW = 2 * B;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [RW-1:0] in_rails = '0;
  logic          out_ack = 1'b0;
  logic          in_accept, out_valid, code_err;
  logic [RW-1:0] out_rails;
  logic [S-1:0]  stage_pc, stage_done;

  int            n_chk = 0;
  int            n_fail = 0;
  bit            done_flag = 1'b0;
  bit            sink_en = 1'b0;
  bit            mon_en = 1'b0;
  logic [RW-1:0] rec [64];
  int            rec_n = 0;
  int            la_viol = 0;
  int            la_early = 0;
  logic [S-1:0]  prev_pc = '0;
  logic [S+1:0]  prev_dx = '0;
  bit            prev_ok = 1'b0;

  lp_pipe #(.STAGES(S), .BITS(B)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_rails   (in_rails),
    .in_accept  (in_accept),
    .out_rails  (out_rails),
    .out_valid  (out_valid),
    .out_ack    (out_ack),
    .code_err   (code_err),
    .stage_pc   (stage_pc),
    .stage_done (stage_done)
  );

  always #2 clk = ~clk;

  function automatic logic [RW-1:0] enc(input logic [B-1:0] v);
    logic [RW-1:0] r;
    for (int b = 0; b < B; b++) r[2*b+1 -: 2] = v[b] ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // sink model first, then the phase monitor, in one process
  always @(negedge clk) begin
    if (!rst_n) begin
      out_ack = 1'b0;
      rec_n   = 0;
    end else if (sink_en && out_valid && !out_ack) begin
      if (rec_n < 64) rec[rec_n] = out_rails;
      rec_n++;
      out_ack = 1'b1;
    end else if (out_ack && !out_valid) begin
      out_ack = 1'b0;
    end
    if (mon_en && prev_ok) begin
      for (int i = 0; i < S; i++) begin
        if (prev_pc[i] && prev_dx[i+2]) begin
          if (stage_pc[i]) la_viol++;
          if (prev_dx[i+1]) la_early++;
        end
      end
    end
    prev_pc = stage_pc;
    prev_dx = {1'b1, out_ack, stage_done};
    prev_ok = mon_en;
  end

  task automatic do_reset();
    @(negedge clk);
    #1;
    rst_n = 1'b0; sink_en = 1'b0; mon_en = 1'b0;
    in_valid = 1'b0; in_rails = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    mon_en = 1'b1;
  endtask

  task automatic send(input logic [RW-1:0] r, input int max_wait, output bit acc);
    @(negedge clk);
    in_rails = r; in_valid = 1'b1; acc = 1'b0;
    for (int k = 0; k < max_wait && !acc; k++) begin
      #1;
      if (in_accept) acc = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0; in_rails = '0;
  endtask

  task automatic wait_rec(input int target, input int max_cyc);
    for (int k = 0; k < max_cyc && rec_n < target; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; sink_en = 1'b0; mon_en = 1'b0;
    in_valid = 1'b0; in_rails = '0;
    repeat (2) @(negedge clk);
    chk(stage_pc == '1, "R1", "precharge in reset", 32'(stage_pc), 32'hF);
    chk(stage_done == '0, "R1", "completion in reset", 32'(stage_done), 0);
    chk(out_valid == 1'b0 && out_rails == '0, "R1", "output in reset", 32'(out_rails), 0);
    chk(code_err == 1'b0 && in_accept == 1'b0, "R1", "err/accept in reset",
        32'({code_err, in_accept}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(stage_pc == '0, "R1", "all evaluate after release (R6)", 32'(stage_pc), 0);
    mon_en = 1'b1;
  endtask

  task automatic t_stream();
    logic [B-1:0] vals [6];
    int base, v0, e0;
    bit acc;
    vals = '{4'h3, 4'hC, 4'h0, 4'hF, 4'h9, 4'h6};
    do_reset();
    #1 sink_en = 1'b1;
    base = rec_n; v0 = la_viol; e0 = la_early;
    for (int i = 0; i < 6; i++) begin
      send(enc(vals[i]), 40, acc);
      chk(acc, "R3", "stream word accepted", 32'(acc), 1);
    end
    wait_rec(base + 6, 100);
    chk(rec_n - base == 6, "R9", "stream count", 32'(rec_n - base), 6);
    for (int i = 0; i < 6; i++)
      chk(rec[base+i] == enc(vals[i]), "R9", "stream order (R2 code)",
          32'(rec[base+i]), 32'(enc(vals[i])));
    chk(la_viol == v0, "R6", "lookahead exit missed", 32'(la_viol - v0), 0);
    chk(la_early > e0, "R6", "early exit seen while successor done", 32'(la_early - e0), 1);
  endtask

  task automatic t_hold();
    int base, acc_cnt;
    do_reset();
    #1 sink_en = 1'b1;
    base = rec_n; acc_cnt = 0;
    @(negedge clk);
    in_rails = enc(4'h5); in_valid = 1'b1;
    for (int k = 0; k < 12; k++) begin
      #1;
      if (in_accept) acc_cnt++;
      @(negedge clk);
    end
    in_valid = 1'b0; in_rails = '0;
    wait_rec(base + 1, 30);
    repeat (10) @(negedge clk);
    chk(acc_cnt == 1, "R3", "held word taken once", 32'(acc_cnt), 1);
    chk(rec_n - base == 1, "R9", "held word emitted once", 32'(rec_n - base), 1);
    chk(rec[base] == enc(4'h5), "R9", "held word value", 32'(rec[base]), 32'(enc(4'h5)));
  endtask

  task automatic t_illegal();
    int base, acc_cnt;
    bit acc;
    logic [RW-1:0] bad;
    do_reset();
    #1 sink_en = 1'b1;
    base = rec_n; acc_cnt = 0;
    bad = enc(4'hA);
    bad[5:4] = 2'b11;
    @(negedge clk);
    in_rails = bad; in_valid = 1'b1;
    for (int k = 0; k < 6; k++) begin
      #1;
      if (in_accept) acc_cnt++;
      @(negedge clk);
    end
    in_valid = 1'b0; in_rails = '0;
    chk(acc_cnt == 0, "R4", "illegal word accepted", 32'(acc_cnt), 0);
    chk(code_err == 1'b1, "R4", "error flag set", 32'(code_err), 1);
    repeat (6) @(negedge clk);
    chk(code_err == 1'b1, "R4", "error flag sticky", 32'(code_err), 1);
    chk(rec_n == base && !out_valid, "R4", "nothing emitted", 32'(rec_n - base), 0);
    send(enc(4'h7), 40, acc);
    wait_rec(base + 1, 30);
    chk(rec_n - base == 1 && rec[base] == enc(4'h7), "R4", "legal word after error",
        32'(rec[base]), 32'(enc(4'h7)));
    do_reset();
    chk(code_err == 1'b0, "R4", "error cleared by reset", 32'(code_err), 0);
  endtask

  task automatic t_capacity();
    int base;
    bit acc;
    do_reset();
    base = rec_n;
    send(enc(4'h1), 40, acc);
    chk(acc, "R8", "first word accepted", 32'(acc), 1);
    send(enc(4'h2), 40, acc);
    chk(acc, "R8", "second word accepted", 32'(acc), 1);
    send(enc(4'h4), 40, acc);
    chk(!acc, "R8", "third word refused when stalled", 32'(acc), 0);
    chk(stage_done == 4'b1010, "R8", "stalled completions", 32'(stage_done), 32'hA);
    chk(stage_pc == 4'b0101, "R8", "stalled precharge", 32'(stage_pc), 32'h5);
    chk(out_valid && out_rails == enc(4'h1), "R10", "output held without ack",
        32'(out_rails), 32'(enc(4'h1)));
    chk(stage_pc[S-1] == 1'b0, "R5", "last stage in evaluate before ack", 32'(stage_pc[S-1]), 0);
    #1 sink_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10", "out_valid falls after ack", 32'(out_valid), 0);
    chk(stage_pc[S-1] == 1'b1, "R5", "last stage precharges after ack", 32'(stage_pc[S-1]), 1);
    wait_rec(base + 2, 60);
    chk(rec_n - base == 2, "R9", "stalled words drained", 32'(rec_n - base), 2);
    chk(rec[base] == enc(4'h1) && rec[base+1] == enc(4'h2), "R9", "drain order",
        32'(rec[base+1]), 32'(enc(4'h2)));
    send(enc(4'h4), 40, acc);
    wait_rec(base + 3, 40);
    chk(rec_n - base == 3 && rec[base+2] == enc(4'h4), "R9", "refused word later delivered",
        32'(rec[base+2]), 32'(enc(4'h4)));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stream();
    t_hold();
    t_illegal();
    t_capacity();
    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule